// File: doc/BRIEF.md
# Multiplexed Host Read Port

This block is the slave side of a host port that serves read cycles from an external host. Address and data share one bus. The host selects the port through one of two chip selects, one for memory space and one for I/O space. It strobes the address in with an address-latch pulse and then pulls one read strobe per bus beat. The port fetches the addressed word once through a request/grant interface to internal memory. The grant delay of that interface stands for contention on the internal bus. The port then returns the word as a series of bytes or half-words, least significant part first.

The port drives one handshake line. Two conventions are available. In acknowledge mode the line is low at rest and goes high once the beat's data is on the bus. In ready mode the line is high at rest and is pulled low to insert wait states while the first beat's data is being fetched. Configuration inputs choose the handshake mode, the bus width (8 or 16 bits) and the word width (16 or 24 bits). All host inputs are sampled on the port clock.

Top module: `mux_host_rd_port`

## Requirements
- R1: The address on `hst_ad_in` is captured in the cycle in which `hst_ale` is seen falling, and only if a chip select was high when `hst_ale` rose and is still high at that moment. The captured value appears on `mem_addr`, and `mem_space` is 1 when the I/O select made the access.
- R2: A rising edge of `hst_rd` that arrives while `hst_ale` is high is ignored. This holds even if the strobe stays high after `hst_ale` falls: no memory request is made, no data is driven and no acknowledge is given.
- R3: On the first beat in acknowledge mode, `hst_hs` rises T cycles after the clock edge that samples the read strobe rising. T = max(FIRST_LAT, g+1), where g is the number of edges up to and including the one that samples `mem_gnt` high. FIRST_LAT defaults to 12.
- R4: On the second and later beats in acknowledge mode, `hst_hs` rises exactly NEXT_LAT cycles after the edge that samples the strobe rising. NEXT_LAT defaults to 3.
- R5: In acknowledge mode, `hst_hs` rises only while `hst_rd` is high. It falls in the cycle after `hst_rd` is sampled low.
- R6: In ready mode, `hst_hs` is high while no fetch is in progress. On the first beat it is low from the edge that samples the strobe rising until T cycles later, with the same T as in R3. Later beats insert no wait: `hst_hs` stays high.
- R7: The number of beats is 2 for an 8-bit bus with 16-bit words, 4 for an 8-bit bus with 24-bit words, 1 for a 16-bit bus with 16-bit words, and 2 for a 16-bit bus with 24-bit words. Beats go out least significant first. The word is zero-extended to 32 bits before it is split. On an 8-bit bus the byte sits in bits 7:0 and bits 15:8 are zero.
- R8: Exactly one internal request is made per transaction, on the first beat. `mem_req` stays high until a grant is sampled and is low in the following cycle.
- R9: Data stays driven (`hst_ad_oe` high) for one cycle after `hst_rd` is sampled low. After that the bus is released, and `hst_ad_out` reads 0 whenever `hst_ad_oe` is low.
- R10: An address-latch pulse made while both chip selects are low starts nothing. A read strobe that follows it produces no request, no data and no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock; all host inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_ready_mode | input | 1 | 1 selects ready-style handshake, 0 selects acknowledge-style |
| cfg_bus16 | input | 1 | 1 for a 16-bit host bus, 0 for an 8-bit bus |
| cfg_word24 | input | 1 | 1 for 24-bit words, 0 for 16-bit words |
| hst_sel_mem | input | 1 | Chip select for memory space, active high |
| hst_sel_io | input | 1 | Chip select for I/O space, active high |
| hst_ale | input | 1 | Address latch strobe, active high |
| hst_rd | input | 1 | Read strobe, active high |
| hst_ad_in | input | 16 | Shared address/data bus, input side |
| hst_ad_out | output | 16 | Shared address/data bus, output side |
| hst_ad_oe | output | 1 | Output enable for the shared bus |
| hst_hs | output | 1 | Handshake line (acknowledge or ready) |
| mem_req | output | 1 | Internal read request |
| mem_addr | output | ADDR_W | Latched address for the internal read |
| mem_space | output | 1 | 1 when the I/O select made the access |
| mem_gnt | input | 1 | Internal grant; read data is valid in the same cycle |
| mem_rdata | input | 24 | Internal read data |

## Verification
The hardest case to reach is the edge of the first-beat latency where the grant delay, not the fixed minimum, decides when the handshake appears. The two terms only trade places inside a narrow band of grant delays. The stimulus therefore sweeps the memory model's grant delay across zero, the crossover band around FIRST_LAT and values well beyond it. It does this in all eight combinations of handshake mode, bus width and word width. A read strobe raised while the latch strobe is still high, and latch pulses made with no chip select, are driven on purpose to show that neither starts a transaction.

// File: rtl/hrp_pkg.sv
package hrp_pkg;

  localparam int BUS_W  = 16;
  localparam int WORD_W = 24;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_ARMED = 3'd1,
    S_WAIT  = 3'd2,
    S_VALID = 3'd3,
    S_HOLD  = 3'd4
  } hrp_state_e;

  // bus beats needed to move one word
  function automatic logic [2:0] beat_count(input logic bus16, input logic word24);
    case ({bus16, word24})
      2'b00:   beat_count = 3'd2;
      2'b01:   beat_count = 3'd4;
      2'b10:   beat_count = 3'd1;
      default: beat_count = 3'd2;
    endcase
  endfunction

endpackage

// File: rtl/hrp_front.sv
module hrp_front #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_mem,
  input  logic              sel_io,
  input  logic              ale,
  input  logic              rd,
  input  logic [15:0]       ad_in,
  output logic              sel_any,
  output logic              rd_rise,
  output logic              addr_load,
  output logic [ADDR_W-1:0] addr_q,
  output logic              space_q
);

  logic              ale_q, rd_q, sel_ok;
  logic              sel_ok_d;
  logic [ADDR_W-1:0] addr_d;
  logic              space_d;

  assign sel_any   = sel_mem | sel_io;
  assign rd_rise   = rd & ~rd_q & ~ale;
  assign addr_load = ale_q & ~ale & sel_ok & sel_any;

  always_comb begin
    sel_ok_d = sel_ok;
    addr_d   = addr_q;
    space_d  = space_q;
    if (ale && !ale_q) sel_ok_d = sel_any;
    if (addr_load) begin
      addr_d  = ad_in[ADDR_W-1:0];
      space_d = sel_io;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_q   <= 1'b0;
      rd_q    <= 1'b0;
      sel_ok  <= 1'b0;
      addr_q  <= '0;
      space_q <= 1'b0;
    end else begin
      ale_q   <= ale;
      rd_q    <= rd;
      sel_ok  <= sel_ok_d;
      addr_q  <= addr_d;
      space_q <= space_d;
    end
  end

endmodule

// File: rtl/hrp_seq.sv
module hrp_seq
  import hrp_pkg::*;
#(
  parameter int FIRST_LAT = 12,
  parameter int NEXT_LAT  = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_ready,
  input  logic       cfg_bus16,
  input  logic       cfg_word24,
  input  logic       addr_load,
  input  logic       sel_any,
  input  logic       rd_rise,
  input  logic       rd_lvl,
  input  logic       mem_gnt,
  output logic       hs,
  output logic       oe,
  output logic       mem_req,
  output logic       buf_load,
  output logic [1:0] beat
);

  localparam int CNT_W = $clog2(FIRST_LAT + NEXT_LAT + 1) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX   = '1;
  localparam logic [CNT_W-1:0] LAT_FIRST = CNT_W'(FIRST_LAT);
  localparam logic [CNT_W-1:0] LAT_NEXT  = CNT_W'(NEXT_LAT);

  hrp_state_e       st, st_d;
  logic [CNT_W-1:0] cnt, cnt_d;
  logic [1:0]       beat_d;
  logic             req_d, have, have_d;
  logic [CNT_W-1:0] lat;
  logic             last;

  assign lat      = (beat == 2'd0) ? LAT_FIRST : LAT_NEXT;
  assign last     = ({1'b0, beat} + 3'd1) == beat_count(cfg_bus16, cfg_word24);
  assign buf_load = mem_req & mem_gnt;
  assign hs       = cfg_ready ? (st != S_WAIT) : (st == S_VALID);
  assign oe       = (st == S_VALID) || (st == S_HOLD);

  always_comb begin
    st_d   = st;
    cnt_d  = cnt;
    beat_d = beat;
    req_d  = mem_req;
    have_d = have;
    case (st)
      S_IDLE: begin
        if (addr_load) begin
          st_d   = S_ARMED;
          beat_d = 2'd0;
        end
      end
      S_ARMED: begin
        if (addr_load) begin
          beat_d = 2'd0;
        end else if (!sel_any) begin
          st_d = S_IDLE;
        end else if (rd_rise) begin
          cnt_d = CNT_W'(1);
          if (beat == 2'd0) begin
            st_d   = S_WAIT;
            req_d  = 1'b1;
            have_d = 1'b0;
          end else if (cfg_ready) begin
            st_d = S_VALID;
          end else begin
            st_d = S_WAIT;
          end
        end
      end
      S_WAIT: begin
        if (cnt != CNT_MAX) cnt_d = cnt + CNT_W'(1);
        if (mem_req && mem_gnt) begin
          req_d  = 1'b0;
          have_d = 1'b1;
        end
        if (have && cnt >= lat) st_d = S_VALID;
      end
      S_VALID: begin
        if (!rd_lvl) st_d = S_HOLD;
      end
      S_HOLD: begin
        beat_d = beat + 2'd1;
        st_d   = last ? S_IDLE : S_ARMED;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      beat    <= 2'd0;
      mem_req <= 1'b0;
      have    <= 1'b0;
    end else begin
      st      <= st_d;
      cnt     <= cnt_d;
      beat    <= beat_d;
      mem_req <= req_d;
      have    <= have_d;
    end
  end

endmodule

// File: rtl/hrp_dpath.sv
module hrp_dpath
  import hrp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              buf_load,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              cfg_bus16,
  input  logic              cfg_word24,
  input  logic [1:0]        beat,
  input  logic              oe,
  output logic [BUS_W-1:0]  ad_out
);

  logic [WORD_W-1:0] wbuf, wbuf_d;
  logic [31:0]       wide;

  always_comb begin
    wbuf_d = wbuf;
    if (buf_load) wbuf_d = mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wbuf <= '0;
    else        wbuf <= wbuf_d;
  end

  assign wide = {8'h00, (cfg_word24 ? wbuf[23:16] : 8'h00), wbuf[15:0]};

  always_comb begin
    if (!oe)            ad_out = '0;
    else if (cfg_bus16) ad_out = wide[{beat[0], 4'b0000} +: 16];
    else                ad_out = {8'h00, wide[{beat, 3'b000} +: 8]};
  end

endmodule

// File: rtl/mux_host_rd_port.sv
module mux_host_rd_port
  import hrp_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int FIRST_LAT = 12,
  parameter int NEXT_LAT  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_ready_mode,
  input  logic              cfg_bus16,
  input  logic              cfg_word24,
  input  logic              hst_sel_mem,
  input  logic              hst_sel_io,
  input  logic              hst_ale,
  input  logic              hst_rd,
  input  logic [15:0]       hst_ad_in,
  output logic [15:0]       hst_ad_out,
  output logic              hst_ad_oe,
  output logic              hst_hs,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_space,
  input  logic              mem_gnt,
  input  logic [23:0]       mem_rdata
);

  logic [1:0] rst_pipe;
  logic       rst_int_n;
  logic       sel_any, rd_rise, addr_load, buf_load;
  logic [1:0] beat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  hrp_front #(.ADDR_W(ADDR_W)) i_front (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .sel_mem  (hst_sel_mem),
    .sel_io   (hst_sel_io),
    .ale      (hst_ale),
    .rd       (hst_rd),
    .ad_in    (hst_ad_in),
    .sel_any  (sel_any),
    .rd_rise  (rd_rise),
    .addr_load(addr_load),
    .addr_q   (mem_addr),
    .space_q  (mem_space)
  );

  hrp_seq #(.FIRST_LAT(FIRST_LAT), .NEXT_LAT(NEXT_LAT)) i_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cfg_ready (cfg_ready_mode),
    .cfg_bus16 (cfg_bus16),
    .cfg_word24(cfg_word24),
    .addr_load (addr_load),
    .sel_any   (sel_any),
    .rd_rise   (rd_rise),
    .rd_lvl    (hst_rd),
    .mem_gnt   (mem_gnt),
    .hs        (hst_hs),
    .oe        (hst_ad_oe),
    .mem_req   (mem_req),
    .buf_load  (buf_load),
    .beat      (beat)
  );

  hrp_dpath i_dpath (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .buf_load  (buf_load),
    .mem_rdata (mem_rdata),
    .cfg_bus16 (cfg_bus16),
    .cfg_word24(cfg_word24),
    .beat      (beat),
    .oe        (hst_ad_oe),
    .ad_out    (hst_ad_out)
  );

endmodule

// File: rtl/hrp_chk.sv
module hrp_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_ready_mode,
  input logic hst_ale,
  input logic hst_rd,
  input logic hst_hs,
  input logic hst_ad_oe,
  input logic mem_req,
  input logic mem_gnt
);

  // R5: acknowledge only rises under an active read strobe
  a_r5_ack_needs_rd: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_ready_mode && $rose(hst_hs)) |-> hst_rd);

  // R5: acknowledge falls the cycle after the strobe is seen low
  a_r5_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_ready_mode && hst_hs && !hst_rd) |=> !hst_hs);

  // R3: acknowledge never signals without data on the bus
  a_r3_ack_with_data: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_ready_mode && hst_hs) |-> hst_ad_oe);

  // R8: request is held until granted
  a_r8_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> mem_req);

  // R8: request drops after grant
  a_r8_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_gnt) |=> !mem_req);

  // R9: no bus drive while the fetch is outstanding
  a_r9_no_drive_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && hst_ad_oe));

  // R2: a request starts only from a strobe seen with the latch strobe low
  a_r2_req_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(hst_rd && !hst_ale));

endmodule

bind mux_host_rd_port hrp_chk i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_ready_mode(cfg_ready_mode),
  .hst_ale       (hst_ale),
  .hst_rd        (hst_rd),
  .hst_hs        (hst_hs),
  .hst_ad_oe     (hst_ad_oe),
  .mem_req       (mem_req),
  .mem_gnt       (mem_gnt)
);

// File: tb/test_mux_host_rd_port.sv
`timescale 1ns/1ps
module test_mux_host_rd_port;

  localparam int FIRST_LAT = 12;
  localparam int NEXT_LAT  = 3;

  logic        clk;
  logic        rst_n;
  logic        cfg_ready_mode, cfg_bus16, cfg_word24;
  logic        hst_sel_mem, hst_sel_io, hst_ale, hst_rd;
  logic [15:0] hst_ad_in;
  logic [15:0] hst_ad_out;
  logic        hst_ad_oe, hst_hs, mem_req, mem_space, mem_gnt;
  logic [15:0] mem_addr;
  logic [23:0] mem_rdata;

  int checks = 0;
  int errors = 0;
  int gnt_dly = 0;
  int grants = 0;
  logic [15:0] seen_addr;
  logic        seen_space;
  logic [15:0] exp_q[$];
  logic        oe_prev = 1'b0;

  mux_host_rd_port #(.ADDR_W(16), .FIRST_LAT(FIRST_LAT), .NEXT_LAT(NEXT_LAT)) i_mux_host_rd_port (
    .clk(clk), .rst_n(rst_n),
    .cfg_ready_mode(cfg_ready_mode), .cfg_bus16(cfg_bus16), .cfg_word24(cfg_word24),
    .hst_sel_mem(hst_sel_mem), .hst_sel_io(hst_sel_io), .hst_ale(hst_ale), .hst_rd(hst_rd),
    .hst_ad_in(hst_ad_in), .hst_ad_out(hst_ad_out), .hst_ad_oe(hst_ad_oe), .hst_hs(hst_hs),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_space(mem_space),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [23:0] mem_word(input logic [15:0] a);
    return {a[7:0] ^ 8'hA5, a ^ 16'h3C69};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model with a programmable grant delay
  initial begin
    mem_gnt = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_req && !mem_gnt) begin
        repeat (gnt_dly) @(negedge clk);
        mem_gnt    = 1'b1;
        mem_rdata  = mem_word(mem_addr);
        seen_addr  = mem_addr;
        seen_space = mem_space;
        grants++;
        @(negedge clk);
        mem_gnt = 1'b0;
      end
    end
  end

  // scoreboard monitor: compares each beat when the bus is first driven
  always @(negedge clk) begin
    if (hst_ad_oe && !oe_prev) begin
      if (exp_q.size() == 0) begin
        check("R7 unexpected beat", 32'(hst_ad_out), 32'hFFFF_FFFF);
      end else begin
        check("R7 beat data", 32'(hst_ad_out), 32'(exp_q.pop_front()));
      end
    end
    oe_prev = hst_ad_oe;
  end

  task automatic ale_pulse(input logic [15:0] a, input logic mem, input logic io);
    @(negedge clk);
    hst_sel_mem = mem; hst_sel_io = io; hst_ad_in = a; hst_ale = 1'b1;
    @(negedge clk);
    hst_ale = 1'b0;
    @(negedge clk);
    hst_ad_in = 16'hDEAD;
  endtask

  task automatic one_beat(input int exp_t, input string req);
    int got = -1;
    hst_rd = 1'b1;
    for (int k = 0; k < 80; k++) begin
      @(posedge clk); @(negedge clk);
      if (hst_hs) begin got = k; break; end
    end
    check(req, 32'(got), 32'(exp_t));
    @(negedge clk);
    hst_rd = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R9 data held one cycle", 32'(hst_ad_oe), 32'd1);
    if (!cfg_ready_mode) check("R5 ack released", 32'(hst_hs), 32'd0);
    @(posedge clk); @(negedge clk);
    check("R9 bus released", {15'd0, hst_ad_oe, hst_ad_out}, 32'd0);
  endtask

  task automatic read_txn(input logic [15:0] a, input logic io, input int d);
    logic [31:0] w;
    int nb;
    int g0;
    int t;
    w  = {8'h00, (cfg_word24 ? mem_word(a)[23:16] : 8'h00), mem_word(a)[15:0]};
    nb = cfg_bus16 ? (cfg_word24 ? 2 : 1) : (cfg_word24 ? 4 : 2);
    for (int i = 0; i < nb; i++)
      exp_q.push_back(cfg_bus16 ? w[16*i +: 16] : {8'h00, w[8*i +: 8]});
    gnt_dly = d;
    g0 = grants;
    ale_pulse(a, !io, io);
    if (cfg_ready_mode) check("R6 ready at rest", 32'(hst_hs), 32'd1);
    for (int b = 0; b < nb; b++) begin
      if (b == 0) begin
        t = (FIRST_LAT > d + 2) ? FIRST_LAT : d + 2;
        one_beat(t, cfg_ready_mode ? "R6 first-beat wait" : "R3 first-beat latency");
      end else begin
        one_beat(cfg_ready_mode ? 0 : NEXT_LAT, cfg_ready_mode ? "R6 no wait later" : "R4 later latency");
      end
    end
    check("R8 single fetch", 32'(grants - g0), 32'd1);
    check("R1 latched address", 32'(seen_addr), 32'(a));
    check("R1 space", 32'(seen_space), 32'(io));
    check("R7 all beats delivered", 32'(exp_q.size()), 32'd0);
    @(negedge clk);
    hst_sel_mem = 1'b0; hst_sel_io = 1'b0;
  endtask

  task automatic quiet_window(input string req);
    int bad = 0;
    for (int k = 0; k < 25; k++) begin
      @(posedge clk); @(negedge clk);
      if (mem_req || hst_ad_oe || hst_hs) bad++;
    end
    check(req, 32'(bad), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_ready_mode = 1'b0; cfg_bus16 = 1'b0; cfg_word24 = 1'b0;
    hst_sel_mem = 1'b0; hst_sel_io = 1'b0; hst_ale = 1'b0; hst_rd = 1'b0;
    hst_ad_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 reset bus idle", {15'd0, hst_ad_oe, hst_ad_out}, 32'd0);
    check("R5 reset handshake low", 32'(hst_hs), 32'd0);
    check("R8 reset no request", 32'(mem_req), 32'd0);

    // all eight configurations across grant delays
    for (int c = 0; c < 8; c++) begin
      cfg_ready_mode = c[2]; cfg_bus16 = c[1]; cfg_word24 = c[0];
      @(negedge clk);
      read_txn(16'h1000 + 16'(c * 37), 1'b0, 0);
      read_txn(16'h2A00 + 16'(c * 11), 1'b1, FIRST_LAT - 2);
      read_txn(16'h4C10 + 16'(c),      1'b0, FIRST_LAT);
      read_txn(16'h8001 + 16'(c * 5),  1'b1, 20 + c);
      read_txn(16'(16'hF00F ^ $urandom), 1'(c), int'($urandom % 24));
    end

    // R2: read strobe raised while latch strobe still high
    cfg_ready_mode = 1'b0; cfg_bus16 = 1'b1; cfg_word24 = 1'b0;
    @(negedge clk);
    hst_sel_mem = 1'b1; hst_ad_in = 16'h5511; hst_ale = 1'b1;
    @(negedge clk);
    hst_rd = 1'b1;
    @(negedge clk);
    hst_ale = 1'b0;
    @(negedge clk);
    hst_ad_in = 16'hDEAD;
    quiet_window("R2 strobe during latch ignored");
    hst_rd = 1'b0;
    @(negedge clk);
    exp_q.push_back(mem_word(16'h5511)[15:0]);
    gnt_dly = 1;
    one_beat(FIRST_LAT, "R3 read after ignored strobe");
    check("R1 address from late latch", 32'(seen_addr), 32'h5511);
    @(negedge clk);
    hst_sel_mem = 1'b0;

    // R10: latch pulse with no chip select
    repeat (2) @(negedge clk);
    ale_pulse(16'h7777, 1'b0, 1'b0);
    hst_rd = 1'b1;
    quiet_window("R10 unselected latch ignored");
    hst_rd = 1'b0;
    repeat (3) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule